// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block collects 32 interrupt inputs and drives a single active-low interrupt request to a processor. Each source has a mode register, which holds a trigger type and a 3-bit priority, and a vector register with a 32-bit value that software chooses. A trigger type is high level, low level, rising edge or falling edge. Low-level and falling-edge triggers are accepted only on sources that the `EXT_MASK` parameter marks as external. Software turns sources on with a set-command bitmask and off with a clear-command bitmask, and reads the current enables back from a mask register.

Reading the vector register acknowledges the interrupt. The read returns the vector of the highest-priority enabled pending source and pushes that source onto an 8-level nesting stack. A write to the end-of-interrupt register pops the stack. The request output is asserted only while some enabled pending source has a priority strictly above the level being serviced. When nothing qualifies, the read returns a programmable spurious vector and the stack does not change.

Access uses a simple single-cycle register bus. Word addresses 0x00+n hold the mode registers, 0x40+n hold the vector registers, and 0x80 to 0x87 hold the control registers. Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high.

Top module: `vpic_top`

## Requirements
- R1: After reset the mask register reads 0, `irq_n` is 1, the status register (0x81) reads 0 and the spurious-vector register (0x87) reads 0.
- R2: The mode register of source n is at address n. Priority sits in bits [2:0] and the trigger type in bits [5:4]. A write updates the priority only when bit 8 is set and the trigger type only when bit 9 is set, so a field that is not selected keeps its value.
- R3: Trigger codes are 0 high level, 1 rising edge, 2 low level and 3 falling edge. A write of code 2 or 3 to a source not marked in `EXT_MASK` leaves its trigger type unchanged. On a marked source the write takes effect.
- R4: A write to 0x82 sets the enables for the bits that are 1. A write to 0x83 clears the enables for the bits that are 1. A read of 0x84 returns the enables.
- R5: A level source is pending exactly while its input is at the active level: 1 for high level, 0 for low level.
- R6: An edge source latches pending on its active edge and stays pending after the input returns. A write to 0x85 clears the latched pending bit of each source whose bit is 1.
- R7: A read of 0x80 returns the vector at 0x40+n of the winning source and pushes that source onto the nesting stack. The winner is the enabled pending source with the highest priority, and among equal priorities the lowest number wins.
- R8: A read of 0x80 with no source above the current level returns the spurious vector, leaves the stack unchanged, and makes 0x81 read 0 until the next push or pop.
- R9: An acknowledge clears the edge latch of the selected source. A level source stays pending while its input stays active.
- R10: `irq_n` is 0 exactly when an enabled pending source has a priority strictly greater than the priority on top of the stack, or the stack is empty and any enabled source is pending.
- R11: A write to 0x86 pops one nesting level whatever data is written. Eight such writes always return the stack to empty.
- R12: A read of 0x81 returns the number of the source on top of the stack, or 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Word address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_src | input | 32 | Interrupt inputs, synchronous to `clk` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Arbitration is tried with three patterns. Two level sources of equal priority test the lowest-number tie break. A higher-priority edge arriving during service tests pre-emption. A same-priority source arriving during service must not interrupt, which tests the strict-greater rule. A staircase of eight priorities fills the stack and is then drained by eight end-of-interrupt writes. This shows whether the stack depth and pop count line up, and whether level sources that are still active are requested again. Each trigger type is driven separately: a pulse on an edge source must stay latched, while on a level source the pending state must follow the input.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_LOW  = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        RGN_MODE = 2'd0,
        RGN_VEC  = 2'd1,
        RGN_CTRL = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    localparam logic [3:0] OFF_ACK     = 4'h0;
    localparam logic [3:0] OFF_STATUS  = 4'h1;
    localparam logic [3:0] OFF_EN_SET  = 4'h2;
    localparam logic [3:0] OFF_EN_CLR  = 4'h3;
    localparam logic [3:0] OFF_EN_READ = 4'h4;
    localparam logic [3:0] OFF_EDGE_CLR= 4'h5;
    localparam logic [3:0] OFF_EOI     = 4'h6;
    localparam logic [3:0] OFF_SPUR    = 4'h7;

    localparam int MODE_TRIG_LSB = 4;
    localparam int MODE_PRIO_WE  = 8;
    localparam int MODE_TRIG_WE  = 9;

    function automatic logic trig_is_edge(trig_e t);
        return (t == TRIG_RISE) || (t == TRIG_FALL);
    endfunction

    function automatic logic trig_is_low(trig_e t);
        return (t == TRIG_LOW) || (t == TRIG_FALL);
    endfunction

    function automatic logic trig_allowed(trig_e t, logic external);
        return external || !trig_is_low(t);
    endfunction

endpackage

// File: rtl/vpic_cond.sv
module vpic_cond
    import vpic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_in,
    input  trig_e trig,
    input  logic  clr,
    output logic  pend
);
    logic prev_q;
    logic edge_q;
    logic edge_hit;

    always_comb begin
        if (trig_is_low(trig))
            edge_hit = !src_in && prev_q;
        else
            edge_hit = src_in && !prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= src_in;
            edge_q <= 1'b0;
        end else begin
            prev_q <= src_in;
            if (trig_is_edge(trig) && edge_hit)
                edge_q <= 1'b1;
            else if (clr)
                edge_q <= 1'b0;
        end
    end

    assign pend = trig_is_edge(trig) ? edge_q : (src_in ^ trig_is_low(trig));
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           win_valid,
    output logic [IDX_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!win_valid || prio[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 5,
    parameter int PRIO_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [CNT_W-1:0]  count,
    output logic [IDX_W-1:0]  top_idx,
    output logic [PRIO_W-1:0] top_prio
);
    logic [IDX_W-1:0]  idx_mem  [DEPTH];
    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [PTR_W-1:0]  top_ptr;

    assign top_ptr  = PTR_W'(count - CNT_W'(1));
    assign top_idx  = (count != '0) ? idx_mem[top_ptr]  : '0;
    assign top_prio = (count != '0) ? prio_mem[top_ptr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                idx_mem[i]  <= '0;
                prio_mem[i] <= '0;
            end
        end else if (push && count < CNT_W'(DEPTH)) begin
            idx_mem[PTR_W'(count)]  <= push_idx;
            prio_mem[PTR_W'(count)] <= push_prio;
            count <= count + CNT_W'(1);
        end else if (pop && count != '0) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int          NUM_SRC     = 32,
    parameter int          PRIO_W      = 3,
    parameter int          STACK_DEPTH = 8,
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] EXT_MASK    = 32'hE000_0001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_n
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    trig_e                          trig_q [NUM_SRC];
    logic [DATA_W-1:0]              vec_q  [NUM_SRC];
    logic [NUM_SRC-1:0]             en_q;
    logic [DATA_W-1:0]              spur_q;
    logic                           spur_ack_q;

    region_e            region;
    logic [IDX_W-1:0]   sel_idx;
    logic [3:0]         ctrl_off;
    logic               ctrl_wr, ack, ack_hit, eoi, preempt;
    logic [NUM_SRC-1:0] pend, cand, clr, ack_clr;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx, top_idx;
    logic [PRIO_W-1:0]  win_prio, top_prio;
    logic [CNT_W-1:0]   stk_count;
    logic [DATA_W-1:0]  status_val;

    assign region   = region_e'(bus_addr[ADDR_W-1 -: 2]);
    assign sel_idx  = bus_addr[IDX_W-1:0];
    assign ctrl_off = bus_addr[3:0];
    assign ctrl_wr  = bus_wr && region == RGN_CTRL;
    assign ack      = bus_rd && !bus_wr && region == RGN_CTRL && ctrl_off == OFF_ACK;
    assign eoi      = ctrl_wr && ctrl_off == OFF_EOI;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        vpic_cond u_cond (
            .clk    (clk),
            .rst    (rst),
            .src_in (irq_src[g]),
            .trig   (trig_q[g]),
            .clr    (clr[g]),
            .pend   (pend[g])
        );
    end

    assign cand = pend & en_q;

    vpic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand      (cand),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    assign preempt = win_valid && (stk_count == '0 || win_prio > top_prio);
    assign ack_hit = ack && preempt;
    assign irq_n   = !preempt;
    assign ack_clr = ack_hit ? (NUM_SRC'(1) << win_idx) : '0;
    assign clr     = ack_clr
                   | ((ctrl_wr && ctrl_off == OFF_EDGE_CLR) ? bus_wdata[NUM_SRC-1:0] : '0);

    vpic_stack #(.DEPTH(STACK_DEPTH), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_hit),
        .push_idx  (win_idx),
        .push_prio (win_prio),
        .pop       (eoi),
        .count     (stk_count),
        .top_idx   (top_idx),
        .top_prio  (top_prio)
    );

    assign status_val = (stk_count == '0 || spur_ack_q) ? '0 : DATA_W'(top_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            spur_q     <= '0;
            spur_ack_q <= 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                prio_q[i] <= '0;
                trig_q[i] <= TRIG_HIGH;
                vec_q[i]  <= '0;
            end
        end else begin
            if (ack && !preempt)
                spur_ack_q <= 1'b1;
            else if (ack_hit || eoi)
                spur_ack_q <= 1'b0;
            if (bus_wr) begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (region == RGN_MODE && sel_idx == IDX_W'(i)) begin
                        if (bus_wdata[MODE_PRIO_WE])
                            prio_q[i] <= bus_wdata[PRIO_W-1:0];
                        if (bus_wdata[MODE_TRIG_WE] &&
                            trig_allowed(trig_e'(bus_wdata[MODE_TRIG_LSB +: 2]), EXT_MASK[i]))
                            trig_q[i] <= trig_e'(bus_wdata[MODE_TRIG_LSB +: 2]);
                    end
                    if (region == RGN_VEC && sel_idx == IDX_W'(i))
                        vec_q[i] <= bus_wdata;
                end
                if (region == RGN_CTRL) begin
                    case (ctrl_off)
                        OFF_EN_SET: en_q   <= en_q | bus_wdata[NUM_SRC-1:0];
                        OFF_EN_CLR: en_q   <= en_q & ~bus_wdata[NUM_SRC-1:0];
                        OFF_SPUR:   spur_q <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (region)
                RGN_MODE: bus_rdata <= DATA_W'({trig_q[sel_idx], {(MODE_TRIG_LSB-PRIO_W){1'b0}}, prio_q[sel_idx]});
                RGN_VEC:  bus_rdata <= vec_q[sel_idx];
                RGN_CTRL: begin
                    case (ctrl_off)
                        OFF_ACK:     bus_rdata <= ack_hit ? vec_q[win_idx] : spur_q;
                        OFF_STATUS:  bus_rdata <= status_val;
                        OFF_EN_READ: bus_rdata <= DATA_W'(en_q);
                        OFF_SPUR:    bus_rdata <= spur_q;
                        default:     bus_rdata <= '0;
                    endcase
                end
                default: bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = 8,
    parameter int ADDR_W      = 8,
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [31:0]        bus_wdata,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] cand,
    input logic [CNT_W-1:0]   stk_count
);
    logic ack_rd, eoi_wr, en_set_wr;
    assign ack_rd    = bus_rd && !bus_wr && bus_addr == ADDR_W'(8'h80);
    assign eoi_wr    = bus_wr && bus_addr == ADDR_W'(8'h86);
    assign en_set_wr = bus_wr && bus_addr == ADDR_W'(8'h82);

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stk_count <= CNT_W'(STACK_DEPTH));

    // R10
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (cand == '0) |-> irq_n);

    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !irq_n) |=> (stk_count == $past(stk_count) + CNT_W'(1)));

    // R8
    spur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && irq_n) |=> $stable(stk_count));

    // R11
    eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && stk_count != '0) |=> (stk_count == $past(stk_count) - CNT_W'(1)));

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        en_set_wr |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));
endmodule

bind vpic_top vpic_chk #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .en_q      (en_q),
    .cand      (cand),
    .stk_count (stk_count)
);

// File: tb/vpic_top_test.sv
module vpic_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = 32'h8000_0001;
    logic        irq_n;
    int          n_chk = 0;
    int          n_fail = 0;

    localparam logic [7:0] A_ACK = 8'h80, A_STAT = 8'h81, A_ESET = 8'h82, A_ECLR = 8'h83,
                           A_EMSK = 8'h84, A_XCLR = 8'h85, A_EOI = 8'h86, A_SPUR = 8'h87;
    localparam logic [31:0] SPUR = 32'hDEAD_0000;

    always #5 clk = ~clk;

    vpic_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic set_src(input int n, input logic v);
        @(negedge clk);
        irq_src[n] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 irq_n", 32'(irq_n), 32'd1);
        rd_chk("R1 mask", A_EMSK, 32'h0);
        rd_chk("R1 status", A_STAT, 32'h0);
        rd_chk("R1 spur", A_SPUR, 32'h0);
        wr(A_SPUR, SPUR);
        rd_chk("R8 spur readback", A_SPUR, SPUR);
    endtask

    task automatic t_mode;
        wr(8'h05, 32'h0000_0314);
        rd_chk("R2 both fields", 8'h05, 32'h14);
        wr(8'h05, 32'h0000_0136);
        rd_chk("R2 prio only", 8'h05, 32'h16);
        wr(8'h05, 32'h0000_0207);
        rd_chk("R2 trig only", 8'h05, 32'h06);
        wr(8'h05, 32'h0000_0220);
        rd_chk("R3 internal low ignored", 8'h05, 32'h06);
        wr(8'h05, 32'h0000_0230);
        rd_chk("R3 internal fall ignored", 8'h05, 32'h06);
        wr(8'h00, 32'h0000_0322);
        rd_chk("R3 external low taken", 8'h00, 32'h22);
    endtask

    task automatic t_enable;
        wr(A_ESET, 32'h0000_00F0);
        wr(A_ECLR, 32'h0000_0030);
        rd_chk("R4 mask", A_EMSK, 32'h0000_00C0);
        wr(A_ECLR, 32'hFFFF_FFFF);
        rd_chk("R4 mask cleared", A_EMSK, 32'h0);
    endtask

    task automatic t_level;
        wr(8'h02, 32'h0000_0301);
        wr(A_ESET, 32'h0000_0005);
        chk("R5 idle", 32'(irq_n), 32'd1);
        set_src(2, 1'b1);
        chk("R5 high active", 32'(irq_n), 32'd0);
        set_src(2, 1'b0);
        chk("R5 high released", 32'(irq_n), 32'd1);
        set_src(0, 1'b0);
        chk("R5 low active", 32'(irq_n), 32'd0);
        set_src(0, 1'b1);
        chk("R5 low released", 32'(irq_n), 32'd1);
        wr(A_ECLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_edge;
        wr(8'h05, 32'h0000_0316);
        wr(8'h45, 32'h0000_5005);
        wr(A_ESET, 32'h0000_0020);
        set_src(5, 1'b1);
        set_src(5, 1'b0);
        @(negedge clk);
        chk("R6 rise latched", 32'(irq_n), 32'd0);
        wr(A_XCLR, 32'h0000_0020);
        chk("R6 edge clear", 32'(irq_n), 32'd1);
        wr(8'h1F, 32'h0000_0337);
        wr(8'h5F, 32'h0000_031F);
        wr(A_ESET, 32'h8000_0000);
        set_src(31, 1'b0);
        chk("R6 fall latched", 32'(irq_n), 32'd0);
        rd_chk("R6 fall vector", A_ACK, 32'h0000_031F);
        rd_chk("R12 status fall", A_STAT, 32'd31);
        set_src(31, 1'b1);
        chk("R6 no latch on rise", 32'(irq_n), 32'd1);
        wr(A_EOI, 32'h0);
        rd_chk("R11 status after pop", A_STAT, 32'd0);
        wr(A_ECLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_arb;
        wr(8'h03, 32'h0000_0302);
        wr(8'h04, 32'h0000_0302);
        wr(8'h43, 32'h0000_0033);
        wr(8'h44, 32'h0000_0044);
        wr(A_ESET, 32'h0000_0038);
        @(negedge clk);
        irq_src[3] = 1'b1; irq_src[4] = 1'b1;
        @(negedge clk);
        chk("R10 idle request", 32'(irq_n), 32'd0);
        rd_chk("R7 tie lowest", A_ACK, 32'h0000_0033);
        rd_chk("R12 status 3", A_STAT, 32'd3);
        chk("R10 equal prio no request", 32'(irq_n), 32'd1);
        set_src(5, 1'b1);
        set_src(5, 1'b0);
        chk("R10 higher preempts", 32'(irq_n), 32'd0);
        rd_chk("R7 preempt vector", A_ACK, 32'h0000_5005);
        rd_chk("R12 status 5", A_STAT, 32'd5);
        chk("R9 edge cleared by ack", 32'(irq_n), 32'd1);
        rd_chk("R8 spurious vector", A_ACK, SPUR);
        rd_chk("R8 status zero", A_STAT, 32'd0);
        wr(A_EOI, 32'hFFFF_FFFF);
        rd_chk("R11 pop data ignored", A_STAT, 32'd3);
        chk("R10 after pop", 32'(irq_n), 32'd1);
        wr(A_EOI, 32'h0);
        chk("R9 level still pending", 32'(irq_n), 32'd0);
        rd_chk("R9 level acked again", A_ACK, 32'h0000_0033);
        @(negedge clk);
        irq_src[3] = 1'b0; irq_src[4] = 1'b0;
        for (int k = 0; k < 8; k++) wr(A_EOI, 32'h0);
        rd_chk("R11 empty after eight", A_STAT, 32'd0);
        chk("R11 no request", 32'(irq_n), 32'd1);
        wr(A_ECLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_nest;
        for (int k = 0; k < 8; k++) begin
            wr(8'(8 + k), 32'h0000_0300 | 32'(k));
            wr(8'(8'h48 + k), 32'h0000_0100 + 32'(k));
        end
        wr(A_ESET, 32'h0000_FF00);
        for (int k = 0; k < 8; k++) begin
            set_src(8 + k, 1'b1);
            rd_chk("R7 staircase vector", A_ACK, 32'h0000_0100 + 32'(k));
        end
        rd_chk("R12 status full", A_STAT, 32'd15);
        chk("R10 full no request", 32'(irq_n), 32'd1);
        rd_chk("R8 full spurious", A_ACK, SPUR);
        for (int k = 0; k < 8; k++) wr(A_EOI, 32'h0);
        rd_chk("R11 full drained", A_STAT, 32'd0);
        chk("R11 pending re-requested", 32'(irq_n), 32'd0);
        @(negedge clk);
        irq_src[15:8] = '0;
        @(negedge clk);
        chk("R5 released all", 32'(irq_n), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode();
        t_enable();
        t_level();
        t_edge();
        t_arb();
        t_nest();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule